// File: doc/BRIEF.md
# Gray-Coded Beam Time-Stamp Generator

This block produces the event time stamp that a front end attaches to its hits. It counts beam-clock periods into an 8-bit value and presents that value both in plain binary and in Gray code. Adjacent time intervals then differ in a single bit, so a hit sampled close to an interval boundary lands at most one interval away from where it belongs.

The beam clock comes from one of two places, chosen by a static select pin. It is either an internal divider of the system clock or an external beam-clock wire. The external wire is synchronised into the system clock and its rising edges are counted. A beam-enable input gates counting, so that beam spills can be followed or imitated. A precision time-reset pulse, sent to every front end at once, zeroes the count and restarts the internal divider.

Alongside the 8-bit value the block keeps a wider extended stamp for debugging and offline timing. Its upper part counts the wraps of the 8-bit value, and the same time-reset clears it, so it stays in step with the 8-bit value.

Top module: `gray_tstamp_gen`

## Requirements
- R1: While `beam_en` is high and `t_rst` is low, every beam-clock period advances `ts_bin` by exactly one, modulo 256.
- R2: `ts_gray` is a register that always holds `ts_bin ^ (ts_bin >> 1)` and changes only on a `clk` edge.
- R3: Apart from the edge that takes a time reset, two consecutive values of `ts_gray` differ in at most one bit.
- R4: A `t_rst` sampled high makes `ts_bin`, `ts_gray` and `ets` zero at that edge. No counting happens while `t_rst` stays high.
- R5: Beam-clock periods that occur while `beam_en` is low leave every output unchanged.
- R6: `ets` is `{wrap_count, ts_bin}`. The upper `EXT_W` bits increase by one on each wrap of `ts_bin` from 255 to 0.
- R7: With `ext_sel` = 1, each rising edge of `ext_bclk` (through a two-flop synchroniser) is one beam-clock period, and the internal divider has no effect.
- R8: With `ext_sel` = 0, one beam-clock period passes every `DIV` cycles of `clk`. The first advance after a time reset happens `DIV` edges after the edge that sampled `t_rst`.
- R9: A low `rst_n` asynchronously clears all outputs to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_sel | input | 1 | Static beam-clock source select: 1 = external, 0 = internal divider |
| ext_bclk | input | 1 | External beam clock, asynchronous to `clk` |
| beam_en | input | 1 | Beam-enable qualifier for counting |
| t_rst | input | 1 | Precision time-reset pulse, synchronous to `clk` |
| ts_bin | output | 8 | Time stamp, binary |
| ts_gray | output | 8 | Time stamp, Gray code |
| ets | output | EXT_W+8 | Extended time stamp: wrap count above the 8-bit value |

## Verification
The bench drives a table of beam-clock bursts, some with beam enable low. It checks after each burst that the binary and Gray outputs agree with the expected count. A design that ignored the enable, or counted each level instead of each edge of the external clock, would run ahead of the table. It also crosses the 255-to-0 wrap and checks the extended stamp, where a missing or doubled carry would show directly. Finally it holds a time reset while beam edges arrive, then counts internal-divider periods from the reset edge. A divider whose phase is not restarted would return a count that is off by one.

// File: rtl/gray_tstamp_gen.sv
module gray_tstamp_gen #(
  parameter int EXT_W = 16,
  parameter int DIV   = 4,
  localparam int TS_W  = 8,
  localparam int DIV_W = (DIV > 1) ? $clog2(DIV) : 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  ext_sel,
  input  logic                  ext_bclk,
  input  logic                  beam_en,
  input  logic                  t_rst,
  output logic [TS_W-1:0]       ts_bin,
  output logic [TS_W-1:0]       ts_gray,
  output logic [EXT_W+TS_W-1:0] ets
);

  logic [2:0]       sync_q;
  logic [DIV_W-1:0] div_cnt;
  logic [EXT_W-1:0] wrap_cnt;
  logic [TS_W-1:0]  ts_next;
  logic             int_tick, ext_rise, adv;

  assign int_tick = (div_cnt == DIV_W'(DIV - 1));
  assign ext_rise = sync_q[1] & ~sync_q[2];
  assign adv      = (ext_sel ? ext_rise : int_tick) & beam_en & ~t_rst;
  assign ts_next  = ts_bin + 1'b1;
  assign ets      = {wrap_cnt, ts_bin};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[1:0], ext_bclk};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              div_cnt <= '0;
    else if (t_rst || int_tick) div_cnt <= '0;
    else                     div_cnt <= div_cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ts_bin   <= '0;
      ts_gray  <= '0;
      wrap_cnt <= '0;
    end else if (t_rst) begin
      ts_bin   <= '0;
      ts_gray  <= '0;
      wrap_cnt <= '0;
    end else if (adv) begin
      ts_bin  <= ts_next;
      ts_gray <= ts_next ^ (ts_next >> 1);
      if (ts_bin == '1) wrap_cnt <= wrap_cnt + 1'b1;
    end
  end

  p_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
    adv |=> ts_bin == $past(ts_bin) + 1'b1);

  p_gray_match_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ts_gray == (ts_bin ^ (ts_bin >> 1)));

  p_gray_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !t_rst |=> $countones(ts_gray ^ $past(ts_gray)) <= 1);

  p_treset_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    t_rst |=> (ts_bin == '0 && ets == '0));

  p_hold_no_beam_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!beam_en && !t_rst) |=> ($stable(ts_bin) && $stable(ets)));

  p_wrap_carry_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && ts_bin == '1) |=> (ts_bin == '0 && wrap_cnt == $past(wrap_cnt) + 1'b1));

endmodule

// File: tb/gray_tstamp_gen_tb.sv
module gray_tstamp_gen_tb;
  logic clk = 0, rst_n = 0, ext_sel = 1, ext_bclk = 0, beam_en = 0, t_rst = 0;
  logic [7:0]  ts_bin, ts_gray;
  logic [23:0] ets;
  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  gray_tstamp_gen #(.EXT_W(16), .DIV(4)) u_dut (
    .clk(clk), .rst_n(rst_n), .ext_sel(ext_sel), .ext_bclk(ext_bclk),
    .beam_en(beam_en), .t_rst(t_rst), .ts_bin(ts_bin), .ts_gray(ts_gray), .ets(ets));

  // {beam_en, pulses, expected ts_bin}, cumulative
  localparam logic [16:0] VEC [6] = '{
    {1'b1, 8'd5,   8'd5},
    {1'b0, 8'd7,   8'd5},
    {1'b1, 8'd1,   8'd6},
    {1'b1, 8'd20,  8'd26},
    {1'b0, 8'd3,   8'd26},
    {1'b1, 8'd100, 8'd126}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic pulses(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) ext_bclk = 1;
      repeat (3) @(negedge clk);
      ext_bclk = 0;
      repeat (2) @(negedge clk);
    end
    repeat (3) @(negedge clk);
  endtask

  function automatic logic [7:0] gray(input logic [7:0] b);
    return b ^ (b >> 1);
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R9 reset ts_bin", ts_bin, 0);
    chk("R9 reset ets", ets, 0);
    rst_n = 1;
    @(negedge clk);

    for (int v = 0; v < 6; v++) begin
      beam_en = VEC[v][16];
      pulses(int'(VEC[v][15:8]));
      chk("R1/R5/R7 table ts_bin", ts_bin, VEC[v][7:0]);
      chk("R2 table ts_gray", ts_gray, gray(VEC[v][7:0]));
    end

    beam_en = 1;
    repeat (40) @(negedge clk);
    chk("R7 internal divider ignored when external", ts_bin, 126);

    pulses(129);
    chk("R1 before wrap", ts_bin, 255);
    chk("R2 gray at 255", ts_gray, gray(8'd255));
    pulses(1);
    chk("R6 wrap ts_bin", ts_bin, 0);
    chk("R6 wrap ets", ets, 256);
    pulses(44);
    chk("R6 ets after wrap", ets, 300);
    chk("R2 gray after wrap", ts_gray, gray(8'd44));

    t_rst = 1;
    pulses(3);
    chk("R4 held reset ts_bin", ts_bin, 0);
    chk("R4 held reset ets", ets, 0);
    chk("R4 held reset ts_gray", ts_gray, 0);
    @(negedge clk) t_rst = 0;
    pulses(2);
    chk("R1 count after time reset", ts_bin, 2);

    ext_sel = 0;
    @(negedge clk) t_rst = 1;
    @(negedge clk) t_rst = 0;
    repeat (39) @(negedge clk);
    chk("R8 internal before 10th period", ts_bin, 9);
    @(negedge clk);
    chk("R8 internal 10 periods", ts_bin, 10);
    chk("R2 internal gray", ts_gray, gray(8'd10));
    beam_en = 0;
    repeat (20) @(negedge clk);
    chk("R5 internal gated", ts_bin, 10);

    rst_n = 0;
    @(negedge clk);
    chk("R9 async reset", ets, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule